// File: doc/BRIEF.md
# Pipelined Address Bus Controller

This block sequences processor-side bus cycles on a bus whose address and data travel on separate wires. An internal requester presents a transfer: an address, byte enables, a direction, a data/control kind and a memory/IO space. The controller captures that transfer, puts it on the bus with an address strobe, and holds it there until the external system signals completion with a ready input. Each clock is one bus state. The visible states are idle, T1, T2, T1P, T2P and T2I.

The external system can ask for the next address early by raising a next-address input. If it does so while a cycle is stretched by wait states, the controller takes the next pending request at once. It drives that request's address and definition with the strobe, even though the data phase of the current cycle has not ended. The cycle that follows then runs in pipelined form, T1P then T2P, and the system has one more state of access time. If the system stops asking, or no request is waiting, the controller falls back to non-pipelined timing. A new series always begins non-pipelined after reset or after an idle state.

Top module: `pipe_addr_bus_ctrl`

## Requirements
- R1: While reset is applied and just after it, the state output reads idle (code 0) and the strobe `bus_ads` is low.
- R2: In idle, a valid request is accepted in that clock. The next state is T1 (code 1), with the strobe high and the captured address, byte enables and definition on the bus. T2 (code 2) always follows T1. The first cycle after reset or idle is therefore never pipelined.
- R3: The state stays T2 while `bus_ready` is low. With no early issue, the bus address, byte enables and definition stay unchanged across those wait states. They change only in the state after an accept.
- R4: When `bus_ready` is high in T2 or T2P and no early address is outstanding, a valid request is accepted and the next state is T1 (non-pipelined back-to-back). With no request the next state is idle.
- R5: In T2 with `bus_ready` low, `bus_na` high, a valid request and no early address outstanding, the request is accepted. The next state is still T2, with the strobe high and the new address on the bus. `bus_na` has no effect in a T2 where `bus_ready` is high.
- R6: When `bus_ready` is high in T2 or T2P and an early address is outstanding, the next state is T1P (code 3) with the strobe low. From T1P the state moves to T2P (code 4) when a request is valid, and to T2I (code 5) when none is valid.
- R7: In T1P, `bus_na` high with a valid request accepts it, and the following T2P shows the new address with the strobe high. In T2P with `bus_ready` low, `bus_na` high, a valid request and nothing outstanding, the same happens and the state stays T2P.
- R8: In T2I no request is accepted and the address is held. When `bus_ready` is high the state goes to idle, and a later request starts a non-pipelined T1.
- R9: At most one early address is issued per bus cycle. While one is outstanding, `req_accept` stays low until the controller enters T1P.
- R10: `bus_ads` is high in exactly those states that directly follow a clock in which `req_accept` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Internal request pending |
| req_addr | input | ADDR_W | Request word address |
| req_be | input | BE_W | Request byte enables |
| req_write | input | 1 | Request direction, 1 = write |
| req_data | input | 1 | Request kind, 1 = data, 0 = control |
| req_mem | input | 1 | Request space, 1 = memory, 0 = IO |
| req_accept | output | 1 | Request captured at this clock edge |
| bus_ready | input | 1 | Current cycle completes at this edge |
| bus_na | input | 1 | External request for the next address |
| bus_addr | output | ADDR_W | Bus address |
| bus_be | output | BE_W | Bus byte enables |
| bus_write | output | 1 | Bus direction |
| bus_data | output | 1 | Bus data/control kind |
| bus_mem | output | 1 | Bus memory/IO space |
| bus_ads | output | 1 | Address strobe, high when a new address is valid |
| bus_state | output | 3 | Bus state code: 0 idle, 1 T1, 2 T2, 3 T1P, 4 T2P, 5 T2I |

## Verification
The bench builds the controller with a 16-bit address and 2 byte enables instead of the defaults. Narrower fields make changes of address and byte enables easy to tell apart in the random stream and in failure messages, and they show that the definition register follows the parameters. The state sequencing does not depend on these widths, so every state, every transition and the early-issue-while-outstanding blocking case are reached under random ready, next-address and request patterns.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T1P  = 3'd3,
    ST_T2P  = 3'd4,
    ST_T2I  = 3'd5
  } bus_st_e;
endpackage

// File: rtl/bpc_seq.sv
// Bus-state sequencer: decides when a request is taken and which state follows.
module bpc_seq
  import bpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    bus_ready,
  input  logic    bus_na,
  output bus_st_e state_q,
  output logic    accept,
  output logic    ads_q
);
  bus_st_e state_d;
  logic    pend_q, pend_d;
  logic    early;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    early   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_T1;
        end
      end
      ST_T1: state_d = ST_T2;
      ST_T2, ST_T2P: begin
        if (bus_ready) begin
          if (pend_q) begin
            state_d = ST_T1P;
          end else if (req_valid) begin
            accept  = 1'b1;
            state_d = ST_T1;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (bus_na && !pend_q && req_valid) begin
          // wait state: next address goes out early, state unchanged
          accept = 1'b1;
          early  = 1'b1;
        end
      end
      ST_T1P: begin
        state_d = req_valid ? ST_T2P : ST_T2I;
        if (bus_na && req_valid) begin
          accept = 1'b1;
          early  = 1'b1;
        end
      end
      ST_T2I: begin
        if (bus_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (early)                 pend_d = 1'b1;
    else if (state_d == ST_T1P) pend_d = 1'b0;
    else                        pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      ads_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      ads_q   <= accept;
    end
  end
endmodule

// File: rtl/bpc_hold.sv
// Load-enabled holding register for the address and cycle definition.
module bpc_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/pipe_addr_bus_ctrl.sv
module pipe_addr_bus_ctrl
  import bpc_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_write,
  input  logic              req_data,
  input  logic              req_mem,
  output logic              req_accept,
  input  logic              bus_ready,
  input  logic              bus_na,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_be,
  output logic              bus_write,
  output logic              bus_data,
  output logic              bus_mem,
  output logic              bus_ads,
  output logic [2:0]        bus_state
);
  localparam int DEF_W = ADDR_W + BE_W + 3;

  logic [1:0]       rs_q;
  logic             srst_n;
  bus_st_e          st;
  logic [DEF_W-1:0] def_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  bpc_seq u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .bus_ready (bus_ready),
    .bus_na    (bus_na),
    .state_q   (st),
    .accept    (req_accept),
    .ads_q     (bus_ads)
  );

  bpc_hold #(.W(DEF_W)) u_def (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (req_accept),
    .d     ({req_addr, req_be, req_write, req_data, req_mem}),
    .q     (def_q)
  );

  assign {bus_addr, bus_be, bus_write, bus_data, bus_mem} = def_q;
  assign bus_state = st;
endmodule

// File: rtl/bpc_chk.sv
module bpc_chk #(
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_accept,
  input logic              bus_ready,
  input logic              bus_ads,
  input logic [2:0]        bus_state,
  input logic [ADDR_W-1:0] bus_addr
);
  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd2 && !bus_ready) |=> (bus_state == 3'd2));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_accept |=> $stable(bus_addr));

  p_idle_to_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd0 && req_accept) |=> (bus_state == 3'd1));

  p_ready_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd2 && bus_ready) |=> (bus_ads == (bus_state == 3'd1)));

  p_t1p_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd3) |-> ($past(bus_state) == 3'd2 || $past(bus_state) == 3'd4));

  p_t2i_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd5) |=> (bus_state == 3'd5 || bus_state == 3'd0));

  p_no_accept_t2i_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd5) |-> !req_accept);

  p_ads_follows_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> bus_ads);

  p_ads_only_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_accept |=> !bus_ads);
endmodule

bind pipe_addr_bus_ctrl bpc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_accept (req_accept),
  .bus_ready  (bus_ready),
  .bus_ads    (bus_ads),
  .bus_state  (bus_state),
  .bus_addr   (bus_addr)
);

// File: tb/pipe_addr_bus_ctrl_tb.sv
module pipe_addr_bus_ctrl_tb;
  localparam int AW = 16;
  localparam int BW = 2;
  localparam int DW = AW + BW + 3;
  localparam logic [2:0] S_IDLE = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2,
                         S_T1P = 3'd3, S_T2P = 3'd4, S_T2I = 3'd5;

  logic clk, rst_n;
  logic req_valid, req_write, req_data, req_mem, req_accept;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_be;
  logic bus_ready, bus_na, bus_write, bus_data, bus_mem, bus_ads;
  logic [AW-1:0] bus_addr;
  logic [BW-1:0] bus_be;
  logic [2:0] bus_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [2:0]    m_st;
  logic          m_pend, m_ads;
  logic [DW-1:0] m_def;

  pipe_addr_bus_ctrl #(.ADDR_W(AW), .BE_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_be(req_be), .req_write(req_write), .req_data(req_data),
    .req_mem(req_mem), .req_accept(req_accept), .bus_ready(bus_ready),
    .bus_na(bus_na), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_write(bus_write), .bus_data(bus_data), .bus_mem(bus_mem),
    .bus_ads(bus_ads), .bus_state(bus_state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string st_tag(input logic [2:0] s);
    case (s)
      S_IDLE, S_T1: return "R2";
      S_T2:         return "R3";
      S_T1P:        return "R6";
      S_T2P:        return "R7";
      default:      return "R8";
    endcase
  endfunction

  function automatic logic exp_acc(input logic [2:0] s, input logic p,
                                   input logic v, input logic na, input logic rd);
    case (s)
      S_IDLE:      return v;
      S_T2, S_T2P: return v && !p && (rd || na);
      S_T1P:       return v && na;
      default:     return 1'b0;
    endcase
  endfunction

  task automatic cyc(input logic v, input logic na, input logic rd,
                     input logic [AW-1:0] a, input logic [BW-1:0] b, input logic [2:0] d);
    logic acc, early;
    logic [2:0] nx;
    @(negedge clk);
    req_valid = v; bus_na = na; bus_ready = rd;
    req_addr = a; req_be = b; {req_write, req_data, req_mem} = d;
    #1;
    acc = exp_acc(m_st, m_pend, v, na, rd);
    check(st_tag(m_st), {61'd0, bus_state}, {61'd0, m_st});
    check("R10", {63'd0, bus_ads}, {63'd0, m_ads});
    check("R9", {63'd0, req_accept}, {63'd0, acc});
    check("R3", {43'd0, bus_addr, bus_be, bus_write, bus_data, bus_mem}, {43'd0, m_def});
    @(posedge clk);
    early = acc && (m_st == S_T1P || ((m_st == S_T2 || m_st == S_T2P) && !rd));
    nx = m_st;
    case (m_st)
      S_IDLE: if (v) nx = S_T1;
      S_T1:   nx = S_T2;
      S_T2, S_T2P: if (rd) nx = m_pend ? S_T1P : (v ? S_T1 : S_IDLE);
      S_T1P:  nx = v ? S_T2P : S_T2I;
      S_T2I:  if (rd) nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
    if (early) m_pend = 1'b1;
    else if (nx == S_T1P) m_pend = 1'b0;
    if (acc) m_def = {a, b, d};
    m_ads = acc;
    m_st = nx;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; bus_na = 0; bus_ready = 0;
    req_addr = '0; req_be = '0; req_write = 0; req_data = 0; req_mem = 0;
    m_st = S_IDLE; m_pend = 0; m_ads = 0; m_def = '0;
    repeat (3) @(negedge clk);
    check("R1", {61'd0, bus_state}, 64'd0);
    check("R1", {63'd0, bus_ads}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {61'd0, bus_state}, 64'd0);

    // directed corner cases
    cyc(1, 0, 0, 16'h0123, 2'd1, 3'b101); #2;
    check("R2", {61'd0, bus_state}, S_T1); check("R2", {63'd0, bus_ads}, 64'd1);
    check("R2", {48'd0, bus_addr}, 64'h0123);
    cyc(0, 0, 0, 16'h0, 2'd0, 3'b000); #2;
    check("R2", {61'd0, bus_state}, S_T2);
    cyc(1, 1, 1, 16'h0456, 2'd2, 3'b011); #2;   // NA with READY: not pipelined
    check("R4", {61'd0, bus_state}, S_T1); check("R5", {48'd0, bus_addr}, 64'h0456);
    cyc(0, 0, 0, 16'h0, 2'd0, 3'b000);
    cyc(1, 1, 0, 16'h0789, 2'd3, 3'b110); #2;   // early issue in wait state
    check("R5", {61'd0, bus_state}, S_T2); check("R5", {63'd0, bus_ads}, 64'd1);
    check("R5", {48'd0, bus_addr}, 64'h0789);
    cyc(1, 1, 0, 16'h0abc, 2'd0, 3'b001); #2;   // second early issue blocked
    check("R9", {63'd0, bus_ads}, 64'd0); check("R9", {48'd0, bus_addr}, 64'h0789);
    cyc(1, 0, 1, 16'h0abc, 2'd0, 3'b001); #2;
    check("R6", {61'd0, bus_state}, S_T1P); check("R6", {63'd0, bus_ads}, 64'd0);
    cyc(1, 1, 0, 16'h0abc, 2'd0, 3'b001); #2;
    check("R7", {61'd0, bus_state}, S_T2P); check("R7", {48'd0, bus_addr}, 64'h0abc);
    cyc(0, 0, 1, 16'h0, 2'd0, 3'b000); #2;
    check("R6", {61'd0, bus_state}, S_T1P);
    cyc(0, 0, 0, 16'h0, 2'd0, 3'b000); #2;
    check("R6", {61'd0, bus_state}, S_T2I);
    cyc(1, 1, 0, 16'h0def, 2'd1, 3'b100); #2;
    check("R8", {61'd0, bus_state}, S_T2I); check("R8", {48'd0, bus_addr}, 64'h0abc);
    cyc(1, 1, 1, 16'h0def, 2'd1, 3'b100); #2;
    check("R8", {61'd0, bus_state}, S_IDLE);
    cyc(1, 1, 0, 16'h0def, 2'd1, 3'b100); #2;
    check("R8", {61'd0, bus_state}, S_T1);

    // constrained random traffic
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 10) < 7, ($urandom % 2) == 1, ($urandom % 10) < 6,
          AW'($urandom), BW'($urandom), 3'($urandom));
    end
    done = 1;
    finish_run();
  end
endmodule